// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Decoder

This block is the bus-facing front end of a 16K x 8 serial memory. It watches the two open-drain bus lines with the system clock and finds start and stop conditions and clock edges. It shifts bytes in on rising SCL and sends read bytes out on falling SCL. It pulls SDA low to acknowledge. It decodes the transaction: a control byte, then two word-address bytes for writes, then either data to be stored or data to be returned.

Write data goes to a separate page-write controller as one-cycle strobes, each carrying a pointer and a byte. A commit pulse follows the closing stop. Read data is fetched from the array one byte ahead through a request/response port. The array returns data one clock after the request. While the page-write controller reports an internal programming cycle, the slave stays silent on the bus. The reset input is asynchronous and active low. The block releases it to its own flops through a two-stage synchroniser.

Top module: `ee2w_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a start. It returns the decoder to expecting a control byte from any point, including the middle of a byte. The bytes that follow are then decoded afresh.
- R2: A rise of SDA while SCL is high is a stop. It ends the transaction and releases SDA. If the transaction was a write that delivered at least one data byte, `wr_commit_o` pulses for exactly one cycle. Otherwise it stays low.
- R3: The control byte is taken MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal `chip_sel_i[2:0]`. Bit 0 set means read and clear means write. Any other control byte gets no acknowledge, and every byte after it is ignored until the next start.
- R4: An acknowledge pulls `sda_drive_low_o` high from the SCL fall after the 8th bit to the SCL fall after the 9th clock. It is steady through the whole high phase of the 9th clock. The release after a write-side acknowledge comes on that fall.
- R5: While `busy_i` is high at the end of a byte, that byte gets no acknowledge. The byte also causes no strobe, no fetch and no commit, and the slave ignores the bus until the next start.
- R6: In a write, the first byte after the control byte loads pointer bits 13..8 from its bits 5..0. Its bits 7..6 are ignored. The second byte loads pointer bits 7..0.
- R7: Each later write byte is acknowledged and gives a one-cycle `wr_stb_o` with the current pointer and the byte. Only pointer bits 5..0 then increment, so a 64-byte page wraps onto itself.
- R8: A read fetches the byte at the pointer and increments the pointer at each fetch. The byte is driven MSB first, with each bit changing only after an SCL fall.
- R9: After a read byte, a master acknowledge (SDA low on the 9th clock) makes the slave send the next byte. A missing acknowledge leaves SDA released. All later clocks are then ignored until a start or stop.
- R10: A write of the address followed by a repeated start and a read control byte returns data from the written address.
- R11: A sequential read past address 0x3FFF continues at 0x0000.
- R12: A stop in the middle of a read aborts it. A following current-address read begins one past the last byte fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_drive_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| chip_sel_i | input | 3 | Chip-address pin levels compared with control bits 3..1 |
| busy_i | input | 1 | Internal programming cycle in progress |
| wr_stb_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 14 | Pointer that goes with the write byte |
| wr_data_o | output | 8 | Received write byte |
| wr_commit_o | output | 1 | One-cycle pulse at a stop that ends a write with data |
| rd_req_o | output | 1 | One-cycle read fetch request |
| rd_addr_o | output | 14 | Address of the fetch |
| rd_data_i | input | 8 | Array data, valid one cycle after the request |

## Verification
The slave answers a bus edge three system clocks after the edge reaches the pins: two synchroniser flops, then the output register. A write strobe appears one clock after the eighth rising SCL edge has been seen. Read data is captured two clocks after the request. The bench holds every quarter of an SCL period for eight clocks and drives the lines on the falling system edge. It samples the data line twice during each high phase, once after a quarter and once just before the fall. An acknowledge or data bit therefore counts only when it is settled through the whole high phase. The release checks run a quarter period after the fall, well past the three-clock latency.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam logic [3:0]  DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } state_e;

endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_pipe_q[STAGES-1];
  assign sda_s = sda_pipe_q[STAGES-1];

  // idle bus is high, so all stages reset to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/ee2w_bit_frame.sv
module ee2w_bit_frame #(
  parameter int unsigned BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       scl_rise_i,
  input  logic                       sda_i,
  output logic [$clog2(BITS+1)-1:0]  bcnt_o,
  output logic [BITS-1:0]            rx_byte_o,
  output logic                       byte_done_o,
  output logic                       ack_rise_o
);

  localparam int unsigned CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [BITS-2:0]  sh_q, sh_d;

  always_comb begin
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    if (start_i || stop_i) begin
      bcnt_d = '0;
    end else if (scl_rise_i) begin
      bcnt_d = (bcnt_q == ACK_SLOT) ? '0 : bcnt_q + CNT_ONE;
      if (bcnt_q != ACK_SLOT) sh_d = {sh_q[BITS-3:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      sh_q   <= '0;
    end else begin
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
    end
  end

  assign bcnt_o      = bcnt_q;
  assign rx_byte_o   = {sh_q, sda_i};
  assign byte_done_o = scl_rise_i && (bcnt_q == LAST_BIT) && !start_i && !stop_i;
  assign ack_rise_o  = scl_rise_i && (bcnt_q == ACK_SLOT) && !start_i && !stop_i;

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned PAGE_W      = 6,
  parameter int unsigned CS_W        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_drive_low_o,
  input  logic [CS_W-1:0]             chip_sel_i,
  input  logic                        busy_i,
  output logic                        wr_stb_o,
  output logic [ADDR_W-1:0]           wr_addr_o,
  output logic [ee2w_pkg::BYTE_W-1:0] wr_data_o,
  output logic                        wr_commit_o,
  output logic                        rd_req_o,
  output logic [ADDR_W-1:0]           rd_addr_o,
  input  logic [ee2w_pkg::BYTE_W-1:0] rd_data_i
);

  localparam int unsigned BW    = ee2w_pkg::BYTE_W;
  localparam int unsigned CNT_W = $clog2(BW + 1);
  localparam int unsigned IDX_W = $clog2(BW);
  localparam int unsigned HI_W  = ADDR_W - BW;
  localparam logic [CNT_W-1:0]  ACK_SLOT = CNT_W'(BW);
  localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(BW - 1);
  localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [CNT_W-1:0] bcnt;
  logic [BW-1:0]    rx_byte;
  logic             byte_done, ack_rise;

  ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  ee2w_bit_frame #(.BITS(BW)) u_frame (
    .clk         (clk),
    .rst_n       (rst_ni),
    .start_i     (bus_start),
    .stop_i      (bus_stop),
    .scl_rise_i  (scl_rise),
    .sda_i       (sda_s),
    .bcnt_o      (bcnt),
    .rx_byte_o   (rx_byte),
    .byte_done_o (byte_done),
    .ack_rise_o  (ack_rise)
  );

  ee2w_pkg::state_e  state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ack_ok_q, ack_ok_d;
  logic              sda_low_q, sda_low_d;
  logic [BW-1:0]     tx_q, tx_d;
  logic              got_data_q, got_data_d;
  logic              rd_req_q, rd_req_d, rd_wait_q;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              wr_stb_q, wr_stb_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [BW-1:0]     wr_data_q, wr_data_d;
  logic              commit_q, commit_d;
  logic              ctrl_match;

  assign ctrl_match = (rx_byte[BW-1 -: 4] == ee2w_pkg::DEV_CODE) &&
                      (rx_byte[CS_W:1] == chip_sel_i);

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    ack_ok_d   = ack_ok_q;
    sda_low_d  = sda_low_q;
    tx_d       = tx_q;
    got_data_d = got_data_q;
    rd_req_d   = 1'b0;
    rd_addr_d  = rd_addr_q;
    wr_stb_d   = 1'b0;
    wr_addr_d  = wr_addr_q;
    wr_data_d  = wr_data_q;
    commit_d   = 1'b0;

    if (rd_wait_q) tx_d = rd_data_i;

    if (bus_start) begin
      state_d    = ee2w_pkg::ST_CTRL;
      ack_ok_d   = 1'b0;
      sda_low_d  = 1'b0;
      got_data_d = 1'b0;
    end else if (bus_stop) begin
      state_d    = ee2w_pkg::ST_IDLE;
      ack_ok_d   = 1'b0;
      sda_low_d  = 1'b0;
      got_data_d = 1'b0;
      commit_d   = (state_q == ee2w_pkg::ST_WDATA) && got_data_q;
    end else begin
      if (byte_done) begin
        ack_ok_d = 1'b0;
        case (state_q)
          ee2w_pkg::ST_CTRL: begin
            if (ctrl_match && !busy_i) begin
              ack_ok_d = 1'b1;
              if (rx_byte[0]) begin
                state_d   = ee2w_pkg::ST_RDATA;
                rd_req_d  = 1'b1;
                rd_addr_d = ptr_q;
                ptr_d     = ptr_q + PTR_ONE;
              end else begin
                state_d = ee2w_pkg::ST_ADDR_HI;
              end
            end else begin
              state_d = ee2w_pkg::ST_IDLE;
            end
          end
          ee2w_pkg::ST_ADDR_HI: begin
            if (busy_i) state_d = ee2w_pkg::ST_IDLE;
            else begin
              ack_ok_d                = 1'b1;
              ptr_d[ADDR_W-1:BW]      = rx_byte[HI_W-1:0];
              state_d                 = ee2w_pkg::ST_ADDR_LO;
            end
          end
          ee2w_pkg::ST_ADDR_LO: begin
            if (busy_i) state_d = ee2w_pkg::ST_IDLE;
            else begin
              ack_ok_d       = 1'b1;
              ptr_d[BW-1:0]  = rx_byte;
              state_d        = ee2w_pkg::ST_WDATA;
            end
          end
          ee2w_pkg::ST_WDATA: begin
            if (busy_i) state_d = ee2w_pkg::ST_IDLE;
            else begin
              ack_ok_d            = 1'b1;
              wr_stb_d            = 1'b1;
              wr_addr_d           = ptr_q;
              wr_data_d           = rx_byte;
              got_data_d          = 1'b1;
              ptr_d[PAGE_W-1:0]   = ptr_q[PAGE_W-1:0] + PAGE_ONE;
            end
          end
          default: ;
        endcase
      end

      // master acknowledge slot of a read byte (slave not driving)
      if (ack_rise && (state_q == ee2w_pkg::ST_RDATA) && !sda_low_q) begin
        if (!sda_s) begin
          rd_req_d  = 1'b1;
          rd_addr_d = ptr_q;
          ptr_d     = ptr_q + PTR_ONE;
        end else begin
          state_d = ee2w_pkg::ST_IDLE;
        end
      end

      if (scl_fall) begin
        if (bcnt == ACK_SLOT)                     sda_low_d = ack_ok_q;
        else if (state_q == ee2w_pkg::ST_RDATA)   sda_low_d = ~tx_q[IDX_TOP - bcnt[IDX_W-1:0]];
        else                                      sda_low_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ee2w_pkg::ST_IDLE;
      ptr_q      <= '0;
      ack_ok_q   <= 1'b0;
      sda_low_q  <= 1'b0;
      tx_q       <= '0;
      got_data_q <= 1'b0;
      rd_req_q   <= 1'b0;
      rd_wait_q  <= 1'b0;
      rd_addr_q  <= '0;
      wr_stb_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      ack_ok_q   <= ack_ok_d;
      sda_low_q  <= sda_low_d;
      tx_q       <= tx_d;
      got_data_q <= got_data_d;
      rd_req_q   <= rd_req_d;
      rd_wait_q  <= rd_req_q;
      rd_addr_q  <= rd_addr_d;
      wr_stb_q   <= wr_stb_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
      commit_q   <= commit_d;
    end
  end

  assign sda_drive_low_o = sda_low_q;
  assign wr_stb_o        = wr_stb_q;
  assign wr_addr_o       = wr_addr_q;
  assign wr_data_o       = wr_data_q;
  assign wr_commit_o     = commit_q;
  assign rd_req_o        = rd_req_q;
  assign rd_addr_o       = rd_addr_q;

endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_drive_low_o,
  input logic              wr_stb_o,
  input logic              wr_commit_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [ADDR_W-1:0] ptr_q,
  input ee2w_pkg::state_e  state_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  AST_ACK_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low_o) |-> !scl_i); // R4

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R7

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o); // R2

  AST_COMMIT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> state_q == ee2w_pkg::ST_IDLE); // R2

  AST_FETCH_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> state_q == ee2w_pkg::ST_RDATA); // R8

  AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> ptr_q == $past(rd_addr_o) + ONE); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ee2w_pkg::ST_IDLE |-> !sda_drive_low_o); // R9

endmodule

bind ee2w_slave ee2w_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .scl_i           (scl_i),
  .sda_drive_low_o (sda_drive_low_o),
  .wr_stb_o        (wr_stb_o),
  .wr_commit_o     (wr_commit_o),
  .rd_req_o        (rd_req_o),
  .rd_addr_o       (rd_addr_o),
  .ptr_q           (ptr_q),
  .state_q         (state_q)
);

// File: tb/test_ee2w_slave.sv
`timescale 1ns/1ps
module test_ee2w_slave;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n, m_scl, m_sda, busy;
  logic [2:0]  chip_sel;
  logic        drv, wr_stb, wr_commit, rd_req;
  logic [13:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data = 8'h00;
  logic        sda_line;
  int          n_chk = 0, n_bad = 0, n_stb = 0, n_commit = 0;
  logic [13:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~drv;

  ee2w_slave i_ee2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_drive_low_o(drv), .chip_sel_i(chip_sel), .busy_i(busy),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  function automatic logic [7:0] mdat(input logic [13:0] a);
    return (a[7:0] * 8'd5) ^ {2'b00, a[13:8]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rd_req) rd_data <= mdat(rd_addr);
    if (wr_stb) begin
      log_a[n_stb & 15] <= wr_addr;
      log_d[n_stb & 15] <= wr_data;
      n_stb <= n_stb + 1;
    end
    if (wr_commit) n_commit <= n_commit + 1;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!m_scl) begin m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); end
    m_sda = 1'b0; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b1; qw();
  endtask

  // one bit; seen is high if the line was high at any sample in the high phase
  task automatic clk_bit(input logic b, output logic seen);
    logic s1;
    m_sda = b; qw();
    m_scl = 1'b1; qw();
    s1 = sda_line;
    repeat (Q - 1) @(negedge clk);
    seen = s1 | sda_line;
    @(negedge clk);
    m_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(~mack, s);
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] cs, input logic rd);
    return {4'b1010, cs, rd};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic        ak;
    logic [7:0]  rb;
    int          base_stb, base_com;
    logic [13:0] a_ab;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; busy = 1'b0; chip_sel = 3'b000;
    repeat (4) @(negedge clk);
    check("R4 reset drive", drv, 0);
    check("R7 reset strobe", wr_stb, 0);
    check("R2 reset commit", wr_commit, 0);
    check("R8 reset fetch", rd_req, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3: chip-select sweep over every pin pattern and every control pattern
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        chip_sel = 3'(p);
        bus_start();
        send_byte(ctl(3'(c), 1'b0), ak);
        check("R3 cs match", ak, (p == c));
        if (ak) check("R4 release after ack", drv, 0);
        bus_stop();
      end
    end
    // R3: wrong device codes never acknowledged
    chip_sel = 3'b101;
    for (int code = 0; code < 16; code++) begin
      if (code != 10) begin
        bus_start();
        send_byte({4'(code), 3'b101, 1'b0}, ak);
        check("R3 code mismatch", ak, 0);
        bus_stop();
      end
    end
    // R3: after a mismatch, later bytes are ignored until a start
    bus_start();
    send_byte(ctl(3'b001, 1'b0), ak);
    send_byte(ctl(3'b101, 1'b0), ak);
    check("R3 ignore after mismatch", ak, 0);
    bus_stop();

    // R6/R7/R2: page write with top address bits set and a page wrap
    base_stb = n_stb; base_com = n_commit;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak); check("R7 ctrl ack", ak, 1);
    send_byte(8'hC7, ak);             check("R6 hi ack", ak, 1);
    send_byte(8'h3E, ak);             check("R6 lo ack", ak, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'hA0 + i * 17), ak);
      check("R7 data ack", ak, 1);
    end
    check("R2 no commit before stop", n_commit - base_com, 0);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R2 commit count", n_commit - base_com, 1);
    check("R7 strobe count", n_stb - base_stb, 4);
    for (int i = 0; i < 4; i++) begin
      check("R6 R7 strobe addr", log_a[(base_stb + i) & 15], {8'h1C, 6'(6'h3E + i)});
      check("R7 strobe data", log_d[(base_stb + i) & 15], 8'(8'hA0 + i * 17));
    end

    // R10/R8/R9: random read via dummy address write
    base_com = n_commit;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak);
    send_byte(8'h12, ak);
    send_byte(8'h34, ak);
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak); check("R10 read ctrl ack", ak, 1);
    recv_byte(1'b1, rb); check("R10 random read 0", rb, mdat(14'h1234));
    recv_byte(1'b1, rb); check("R8 sequential 1", rb, mdat(14'h1235));
    recv_byte(1'b0, rb); check("R8 sequential 2", rb, mdat(14'h1236));
    check("R9 released after nack", drv, 0);
    recv_byte(1'b1, rb); check("R9 ignored after nack", rb, 8'hFF);
    bus_stop();
    check("R2 no commit on address-only write", n_commit - base_com, 0);

    // R8: current-address read continues from pointer
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak);
    recv_byte(1'b0, rb); check("R8 current address", rb, mdat(14'h1237));
    bus_stop();

    // R11: wrap at the top of the array
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak);
    send_byte(8'hFF, ak);
    send_byte(8'hFE, ak);
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak);
    recv_byte(1'b1, rb); check("R11 at 3FFE", rb, mdat(14'h3FFE));
    recv_byte(1'b1, rb); check("R11 at 3FFF", rb, mdat(14'h3FFF));
    recv_byte(1'b0, rb); check("R11 wrapped 0000", rb, mdat(14'h0000));
    bus_stop();

    // R12: stop aborts a read after a master ack
    a_ab = 14'h0200;
    while (mdat(a_ab + 14'd1)[7] == 1'b0) a_ab = a_ab + 14'd1;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak);
    send_byte({2'b00, a_ab[13:8]}, ak);
    send_byte(a_ab[7:0], ak);
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak);
    recv_byte(1'b1, rb); check("R12 first byte", rb, mdat(a_ab));
    bus_stop();
    check("R12 released after abort", drv, 0);
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak);
    recv_byte(1'b0, rb); check("R12 resume address", rb, mdat(a_ab + 14'd2));
    bus_stop();

    // R1: start in the middle of a write byte restarts decoding
    base_stb = n_stb;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak);
    send_byte(8'h01, ak);
    send_byte(8'h00, ak);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, ak);
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak); check("R1 ctrl after mid-byte start", ak, 1);
    recv_byte(1'b0, rb); check("R1 read after restart", rb, mdat(14'h0100));
    bus_stop();
    check("R1 no strobe from partial byte", n_stb - base_stb, 0);

    // R5: busy suppresses acknowledges and strobes
    base_stb = n_stb; base_com = n_commit;
    busy = 1'b1;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak); check("R5 busy write ctrl", ak, 0);
    bus_stop();
    bus_start();
    send_byte(ctl(3'b101, 1'b1), ak); check("R5 busy read ctrl", ak, 0);
    recv_byte(1'b0, rb); check("R5 busy no read data", rb, 8'hFF);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(ctl(3'b101, 1'b0), ak);
    send_byte(8'h05, ak);
    send_byte(8'h10, ak);
    busy = 1'b1;
    send_byte(8'h77, ak); check("R5 busy data byte", ak, 0);
    bus_stop();
    busy = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 no strobe while busy", n_stb - base_stb, 0);
    check("R5 no commit while busy", n_commit - base_com, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule